// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block sequences the bus cycles of a four-channel DMA engine. A request that an external priority resolver has already picked is turned into a bus hold request. The block waits for the hold to be granted. It then steps through the address, read and write phases of each transfer, moving the channel's address up by one and its count down by one on every transfer. It also decides, from the channel's transfer mode, whether the burst goes on or the bus is handed back.

Each channel keeps a 16-bit address, a 16-bit count and a 2-bit mode. These are loaded through a plain load port. A channel in cascade mode only passes the acknowledge through to a downstream requester. A separate copy mode moves bytes from the channel 0 address to the channel 1 address with back-to-back cycles. A terminal count is flagged per channel and announced by a one-cycle low pulse on the end-of-process output.

Top module: `dma_xfer_seq`

## Requirements
- R1: After a grant (`grant_valid`, channel `grant_ch`) in idle, `hrq` rises on the next cycle. No acknowledge, strobe or address phase starts until `hlda` is sampled high.
- R2: A channel whose mode is cascade (2'b11) gets `dack` held high once `hlda` is seen, with no read or write strobes. The first cycle after its `dreq` bit is sampled low, `hrq` and `dack` are both low.
- R3: A normal transfer runs, one cycle each: high-address phase (`adstb`=1), low-address phase (`dack` bit asserted), read (`rd_en`), then write (`wr_en`). `bus_addr` carries the channel address throughout.
- R4: With `fast_timing` high, the read phase is skipped. `rd_en` and `wr_en` are then both high in the single write cycle that follows the low-address phase.
- R5: Single mode (2'b01) drops `hrq` and `dack` in the cycle after its one write.
- R6: Block mode (2'b10) keeps transferring whatever `dreq` does. It stops after a write in which the count hit terminal count, or in which `eop_in_n` was low.
- R7: Demand mode (2'b00) stops as block mode does, and also after a write in which the channel's `dreq` bit was low.
- R8: A continuing burst restarts at the high-address phase only if bits 15:8 of the address change on the advance. Otherwise it restarts at the low-address phase with `adstb` low.
- R9: On terminal count, `tc_flags` bit n of the channel sets. `eop_out_n` is low for exactly the first idle cycle after the write, and `hrq` is low in that cycle.
- R10: Each transfer raises the channel address by one and lowers its count by one. Terminal count is the transfer made while the count is zero, so a count of N gives N+1 transfers.
- R11: With `copy_mode` high, `dreq[0]` starts the sequence and `grant_valid` is ignored. After `hlda`, each cycle drives `rd_en` and `wr_en` with source `bus_addr` taken from channel 0 and `dst_addr` taken from channel 1, and both channels advance.
- R12: A copy ends after the cycle in which either channel's count was zero. `tc_flags[1:0]` then become 2'b11 and `req_clr[1:0]` pulses 2'b11 for one cycle.
- R13: After reset: `hrq`=0, `dack`=0, `rd_en`=`wr_en`=`adstb`=0, `eop_out_n`=1 and `tc_flags`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| copy_mode | input | 1 | Selects memory-to-memory copy from channel 0 to channel 1 |
| fast_timing | input | 1 | Compressed timing: read merged into the write cycle |
| ld_en | input | 1 | Load strobe for one channel's registers |
| ld_ch | input | 2 | Channel to load |
| ld_mode | input | 2 | Mode: 00 demand, 01 single, 10 block, 11 cascade |
| ld_addr | input | 16 | Start address |
| ld_cnt | input | 16 | Count (transfers minus one) |
| grant_valid | input | 1 | Resolved request is pending |
| grant_ch | input | 2 | Channel chosen by the resolver |
| dreq | input | 4 | Raw channel requests, active high |
| hlda | input | 1 | Hold acknowledge |
| eop_in_n | input | 1 | External end-of-process, active low |
| hrq | output | 1 | Hold request |
| dack | output | 4 | Per-channel acknowledge, active high |
| adstb | output | 1 | High-address phase strobe |
| bus_addr | output | 16 | Transfer address (copy source in copy mode) |
| dst_addr | output | 16 | Copy destination address |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| eop_out_n | output | 1 | End-of-process output pulse, active low |
| tc_flags | output | 4 | Sticky terminal-count flags per channel |
| req_clr | output | 4 | One-cycle request clear pulse at copy end |

## Verification
The hardest case to reach from the ports is a burst that both takes the low-address shortcut and later has to go back to the high-address phase. That only happens when the address crosses a 256-byte boundary partway through a burst. The bench loads a block-mode channel at 0x00FE with a count of two. It then follows every cycle: the second transfer must start without `adstb`, and the third must start with it at 0x0100. The same burst ends in terminal count, so the one-cycle `eop_out_n` pulse is caught in the idle cycle that follows. Early stops on `eop_in_n` and on a dropped `dreq` are forced by changing those inputs during the write cycle of a chosen transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_AHI,
    ST_ALO,
    ST_READ,
    ST_WRITE,
    ST_CASC,
    ST_COPY
  } seq_state_e;

endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic [CHW-1:0]          ld_ch,
  input  logic [1:0]              ld_mode,
  input  logic [AW-1:0]           ld_addr,
  input  logic [AW-1:0]           ld_cnt,
  input  logic [NCH-1:0]          adv,
  output logic [NCH-1:0][AW-1:0]  addr_q,
  output logic [NCH-1:0][AW-1:0]  cnt_q,
  output logic [NCH-1:0][1:0]     mode_q
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = ld_en && (ld_ch == CHW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
        mode_q[g] <= '0;
      end else if (hit) begin
        addr_q[g] <= ld_addr;
        cnt_q[g]  <= ld_cnt;
        mode_q[g] <= ld_mode;
      end else if (adv[g]) begin
        addr_q[g] <= addr_q[g] + AW'(1);
        cnt_q[g]  <= cnt_q[g] - AW'(1);
      end
    end
  end

endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int LOW_W = AW / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            copy_mode,
  input  logic            fast_timing,
  input  logic            grant_valid,
  input  logic [CHW-1:0]  grant_ch,
  input  logic [NCH-1:0]  dreq,
  input  logic            hlda,
  input  logic            eop_in_n,
  input  logic [1:0]      svc_mode,
  input  logic [AW-1:0]   svc_addr,
  input  logic [AW-1:0]   svc_cnt,
  input  logic [AW-1:0]   cnt0,
  input  logic [AW-1:0]   cnt1,
  output seq_state_e      st_o,
  output logic [CHW-1:0]  svc_o,
  output logic [NCH-1:0]  adv,
  output logic [NCH-1:0]  tc_flags,
  output logic            eop_out_n,
  output logic [NCH-1:0]  req_clr
);

  seq_state_e     st_q, st_d;
  logic [CHW-1:0] svc_q, svc_d;
  logic [NCH-1:0] tc_q, tc_d, clr_q, clr_d;
  logic           eop_q, eop_d;
  logic           at_tc, stop, hi_moves;
  logic [AW-1:0]  addr_nx;

  assign addr_nx  = svc_addr + AW'(1);
  assign hi_moves = (addr_nx[AW-1:LOW_W] != svc_addr[AW-1:LOW_W]);
  assign at_tc    = (svc_cnt == '0);

  always_comb begin
    case (xfer_mode_e'(svc_mode))
      XM_SINGLE: stop = 1'b1;
      XM_BLOCK:  stop = at_tc || !eop_in_n;
      XM_DEMAND: stop = at_tc || !eop_in_n || !dreq[svc_q];
      default:   stop = 1'b1;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    svc_d = svc_q;
    tc_d  = tc_q;
    eop_d = eop_q;
    clr_d = '0;
    adv   = '0;
    case (st_q)
      ST_IDLE: begin
        eop_d = 1'b1;
        if (copy_mode) begin
          if (dreq[0]) begin
            st_d  = ST_HOLD;
            svc_d = '0;
          end
        end else if (grant_valid) begin
          st_d  = ST_HOLD;
          svc_d = grant_ch;
        end
      end
      ST_HOLD: begin
        if (hlda) begin
          if (copy_mode)                      st_d = ST_COPY;
          else if (svc_mode == XM_CASCADE)    st_d = ST_CASC;
          else                                st_d = ST_AHI;
        end
      end
      ST_CASC:  if (!dreq[svc_q]) st_d = ST_IDLE;
      ST_AHI:   st_d = ST_ALO;
      ST_ALO:   st_d = fast_timing ? ST_WRITE : ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: begin
        adv[svc_q] = 1'b1;
        if (at_tc) begin
          tc_d[svc_q] = 1'b1;
          eop_d       = 1'b0;
        end
        if (stop)          st_d = ST_IDLE;
        else if (hi_moves) st_d = ST_AHI;
        else               st_d = ST_ALO;
      end
      ST_COPY: begin
        adv[0] = 1'b1;
        adv[1] = 1'b1;
        if ((cnt0 == '0) || (cnt1 == '0)) begin
          st_d     = ST_IDLE;
          tc_d[0]  = 1'b1;
          tc_d[1]  = 1'b1;
          clr_d[0] = 1'b1;
          clr_d[1] = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      svc_q <= '0;
      tc_q  <= '0;
      eop_q <= 1'b1;
      clr_q <= '0;
    end else begin
      st_q  <= st_d;
      svc_q <= svc_d;
      tc_q  <= tc_d;
      eop_q <= eop_d;
      clr_q <= clr_d;
    end
  end

  assign st_o      = st_q;
  assign svc_o     = svc_q;
  assign tc_flags  = tc_q;
  assign eop_out_n = eop_q;
  assign req_clr   = clr_q;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            copy_mode,
  input  logic            fast_timing,
  input  logic            ld_en,
  input  logic [CHW-1:0]  ld_ch,
  input  logic [1:0]      ld_mode,
  input  logic [AW-1:0]   ld_addr,
  input  logic [AW-1:0]   ld_cnt,
  input  logic            grant_valid,
  input  logic [CHW-1:0]  grant_ch,
  input  logic [NCH-1:0]  dreq,
  input  logic            hlda,
  input  logic            eop_in_n,
  output logic            hrq,
  output logic [NCH-1:0]  dack,
  output logic            adstb,
  output logic [AW-1:0]   bus_addr,
  output logic [AW-1:0]   dst_addr,
  output logic            rd_en,
  output logic            wr_en,
  output logic            eop_out_n,
  output logic [NCH-1:0]  tc_flags,
  output logic [NCH-1:0]  req_clr
);

  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [NCH-1:0][AW-1:0] addr_q, cnt_q;
  logic [NCH-1:0][1:0]    mode_q;
  logic [NCH-1:0]         adv;
  logic [CHW-1:0]         svc;
  seq_state_e             st;

  dma_chan_bank #(.NCH(NCH), .AW(AW)) bank_i (
    .clk(clk), .rst_n(rst_core_n),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_mode(ld_mode),
    .ld_addr(ld_addr), .ld_cnt(ld_cnt), .adv(adv),
    .addr_q(addr_q), .cnt_q(cnt_q), .mode_q(mode_q)
  );

  dma_seq_ctl #(.NCH(NCH), .AW(AW)) ctl_i (
    .clk(clk), .rst_n(rst_core_n),
    .copy_mode(copy_mode), .fast_timing(fast_timing),
    .grant_valid(grant_valid), .grant_ch(grant_ch),
    .dreq(dreq), .hlda(hlda), .eop_in_n(eop_in_n),
    .svc_mode(mode_q[svc]), .svc_addr(addr_q[svc]), .svc_cnt(cnt_q[svc]),
    .cnt0(cnt_q[0]), .cnt1(cnt_q[1]),
    .st_o(st), .svc_o(svc), .adv(adv), .tc_flags(tc_flags),
    .eop_out_n(eop_out_n), .req_clr(req_clr)
  );

  always_comb begin
    dack = '0;
    if (st inside {ST_CASC, ST_ALO, ST_READ, ST_WRITE}) dack[svc] = 1'b1;
  end

  assign hrq      = (st != ST_IDLE);
  assign adstb    = (st == ST_AHI);
  assign rd_en    = (st == ST_READ) || (st == ST_COPY) || ((st == ST_WRITE) && fast_timing);
  assign wr_en    = (st == ST_WRITE) || (st == ST_COPY);
  assign bus_addr = (st == ST_COPY) ? addr_q[0] : addr_q[svc];
  assign dst_addr = addr_q[1];

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hrq,
  input logic [NCH-1:0] dack,
  input logic           adstb,
  input logic           rd_en,
  input logic           wr_en,
  input logic           eop_out_n,
  input logic [NCH-1:0] tc_flags,
  input logic [NCH-1:0] req_clr
);

  assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrq) |-> (dack == '0 && !rd_en && !wr_en && !adstb));

  assert_dack_needs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hrq);

  assert_dack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_read_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |-> $past(rd_en));

  assert_eop_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eop_out_n) |-> (!hrq && (|tc_flags)));

  assert_copy_end_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_clr) |-> (tc_flags[1:0] == 2'b11 && !hrq));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .hrq(hrq), .dack(dack), .adstb(adstb),
  .rd_en(rd_en), .wr_en(wr_en), .eop_out_n(eop_out_n),
  .tc_flags(tc_flags), .req_clr(req_clr)
);

// File: tb/dma_xfer_seq_tb_top.sv
module dma_xfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        copy_mode, fast_timing, ld_en, grant_valid, hlda, eop_in_n;
  logic [1:0]  ld_ch, ld_mode, grant_ch;
  logic [15:0] ld_addr, ld_cnt;
  logic [3:0]  dreq;
  logic        hrq, adstb, rd_en, wr_en, eop_out_n;
  logic [3:0]  dack, tc_flags, req_clr;
  logic [15:0] bus_addr, dst_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .copy_mode(copy_mode), .fast_timing(fast_timing),
    .ld_en(ld_en), .ld_ch(ld_ch), .ld_mode(ld_mode), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .dreq(dreq), .hlda(hlda),
    .eop_in_n(eop_in_n), .hrq(hrq), .dack(dack), .adstb(adstb), .bus_addr(bus_addr),
    .dst_addr(dst_addr), .rd_en(rd_en), .wr_en(wr_en), .eop_out_n(eop_out_n),
    .tc_flags(tc_flags), .req_clr(req_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    copy_mode = 0; fast_timing = 0; ld_en = 0; grant_valid = 0; hlda = 0;
    eop_in_n = 1; ld_ch = 0; ld_mode = 0; grant_ch = 0; ld_addr = 0; ld_cnt = 0;
    dreq = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step(); step(); step();
  endtask

  task automatic load(input logic [1:0] ch, input logic [1:0] md,
                      input logic [15:0] a, input logic [15:0] c);
    ld_en = 1; ld_ch = ch; ld_mode = md; ld_addr = a; ld_cnt = c;
    step();
    ld_en = 0;
  endtask

  task automatic start(input logic [1:0] ch);
    grant_valid = 1; grant_ch = ch; hlda = 0;
    step();
    grant_valid = 0;
    chk("R1 hrq after grant", hrq, 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 hrq", hrq, 0);
    chk("R13 dack", dack, 0);
    chk("R13 strobes", {adstb, rd_en, wr_en}, 0);
    chk("R13 eop_out_n", eop_out_n, 1);
    chk("R13 tc_flags", tc_flags, 0);
  endtask

  task automatic t_hold_wait();
    do_reset();
    load(2'd1, 2'b01, 16'h0100, 16'd3);
    start(2'd1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R1 waiting hrq", hrq, 1);
      chk("R1 waiting quiet", {dack, adstb, rd_en, wr_en}, 0);
    end
    hlda = 1;
    step();
    chk("R1 adstb after hlda", adstb, 1);
  endtask

  task automatic t_single();
    do_reset();
    load(2'd2, 2'b01, 16'h12FE, 16'd1);
    start(2'd2);
    chk("R1 no dack in hold", dack, 0);
    hlda = 1;
    step();
    chk("R3 high addr strobe", adstb, 1);
    chk("R3 bus addr", bus_addr, 16'h12FE);
    step();
    chk("R3 low addr dack", {adstb, dack}, 5'b0_0100);
    chk("R3 no read yet", rd_en, 0);
    step();
    chk("R3 read phase", {rd_en, wr_en}, 2'b10);
    step();
    chk("R3 write phase", {rd_en, wr_en, dack}, 6'b01_0100);
    step();
    chk("R5 release hrq", hrq, 0);
    chk("R5 release dack", dack, 0);
    chk("R10 no tc at count 1", tc_flags, 0);
  endtask

  task automatic t_fast();
    do_reset();
    fast_timing = 1;
    load(2'd0, 2'b01, 16'h0040, 16'd5);
    start(2'd0);
    hlda = 1;
    step(); step();
    chk("R4 low addr", dack, 4'b0001);
    step();
    chk("R4 merged read write", {rd_en, wr_en}, 2'b11);
    step();
    chk("R4 single done", hrq, 0);
  endtask

  task automatic t_block_tc();
    do_reset();
    load(2'd1, 2'b10, 16'h00FE, 16'd2);
    start(2'd1);
    hlda = 1;
    step(); chk("R3 first high addr", {adstb, bus_addr}, {1'b1, 16'h00FE});
    step(); step();
    step(); chk("R6 write 1", wr_en, 1);
    step(); chk("R8 shortcut no adstb", adstb, 0);
    chk("R8 low addr dack", dack, 4'b0010);
    chk("R10 addr incremented", bus_addr, 16'h00FF);
    step(); step();
    chk("R6 write 2", wr_en, 1);
    chk("R9 no eop yet", eop_out_n, 1);
    step(); chk("R8 high byte changed", {adstb, bus_addr}, {1'b1, 16'h0100});
    step(); step(); step();
    chk("R10 third write", {wr_en, eop_out_n}, 2'b11);
    step();
    chk("R9 eop pulse low", eop_out_n, 0);
    chk("R9 tc flag", tc_flags, 4'b0010);
    chk("R9 hrq released", {hrq, dack}, 0);
    step();
    chk("R9 eop back high", eop_out_n, 1);
  endtask

  task automatic t_block_eop();
    do_reset();
    fast_timing = 1;
    load(2'd0, 2'b10, 16'h0010, 16'd10);
    start(2'd0);
    hlda = 1;
    step(); step(); step();
    chk("R6 first write", wr_en, 1);
    step();
    chk("R6 block ignores dreq", hrq, 1);
    chk("R6 next low addr", bus_addr, 16'h0011);
    step();
    eop_in_n = 0;
    step();
    chk("R6 eop stops block", hrq, 0);
    chk("R6 no tc on eop", tc_flags, 0);
    eop_in_n = 1;
  endtask

  task automatic t_demand();
    do_reset();
    fast_timing = 1;
    dreq = 4'b1000;
    load(2'd3, 2'b00, 16'h0400, 16'd10);
    start(2'd3);
    hlda = 1;
    step(); step(); step();
    step();
    chk("R7 demand continues", {hrq, dack}, 5'b1_1000);
    step();
    chk("R7 second write", wr_en, 1);
    dreq = 0;
    step();
    chk("R7 dreq drop stops", hrq, 0);
    chk("R7 no tc", tc_flags, 0);
  endtask

  task automatic t_cascade();
    do_reset();
    dreq = 4'b0100;
    load(2'd2, 2'b11, 16'h0000, 16'd0);
    start(2'd2);
    hlda = 1;
    step();
    chk("R2 cascade dack", {hrq, dack}, 5'b1_0100);
    chk("R2 no strobes", {adstb, rd_en, wr_en}, 0);
    step();
    chk("R2 still cascaded", dack, 4'b0100);
    dreq = 0;
    step();
    chk("R2 release", {hrq, dack}, 0);
  endtask

  task automatic t_copy();
    do_reset();
    copy_mode = 1;
    load(2'd0, 2'b10, 16'h0200, 16'd1);
    load(2'd1, 2'b10, 16'h0300, 16'd5);
    grant_valid = 1; grant_ch = 2'd3;
    step();
    chk("R11 grant ignored in copy", hrq, 0);
    grant_valid = 0;
    dreq = 4'b0001;
    step();
    chk("R11 dreq0 starts copy", hrq, 1);
    hlda = 1;
    step();
    chk("R11 copy byte 0", {rd_en, wr_en, bus_addr, dst_addr}, {2'b11, 16'h0200, 16'h0300});
    chk("R11 no dack", dack, 0);
    step();
    chk("R11 copy byte 1", {bus_addr, dst_addr}, {16'h0201, 16'h0301});
    step();
    chk("R12 copy ended", hrq, 0);
    chk("R12 tc flags", tc_flags, 4'b0011);
    chk("R12 req clear", req_clr, 4'b0011);
    dreq = 0;
    step();
    chk("R12 clear pulse ends", {req_clr, hrq}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    t_reset();
    t_hold_wait();
    t_single();
    t_fast();
    t_block_tc();
    t_block_eop();
    t_demand();
    t_cascade();
    t_copy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule